// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block turns a stream of multichannel audio samples into a time-division-multiplexed serial line. From the master clock it divides down a bit clock and a frame-sync strobe, and in every 32-bit time slot it shifts out one sample, most significant bit first. Samples arrive over a valid/ready port that also carries the target channel number. Each channel has a one-entry store. When the store for a slot is empty at the moment the slot begins, the block sends a fill value instead of a sample and raises a sticky underrun flag. Options select the channel count, the shape of the frame-sync pulse, a one-bit data delay (I2S alignment), mono duplication of left into right, and a loop-back path that routes the serial output into the receive-data input.

The bit clock is sequenced by a three-state machine. `BC_OFF` is the disabled state: outputs are low and the counters are cleared. `BC_LOW` is the low half of a bit period and `BC_HIGH` is the high half. The transitions are as follows. `BC_OFF -> BC_LOW` happens when enable is seen high. `BC_LOW -> BC_HIGH` happens when the low-half count expires. `BC_HIGH -> BC_LOW` happens when the bit period ends, which starts the next bit. Any state goes to `BC_OFF` when enable is seen low. Every entry into `BC_LOW` is a bit start: the serial data either loads a new slot word or shifts by one.

Configuration should only be changed while the block is disabled, except for the loop-back select, which may change at any time.

Top module: `tdm_audio_tx`

## Requirements
- R1: After reset, and while disabled, `sck`, `fsync` and `sd_out` are low, `urun` is low, and `in_ready` is high for any channel whose store is empty.
- R2: The channel count N equals `cfg_nch_m1` plus one, with the field's low bit forced to 1, giving 2, 4, 6 or 8. The master-clock ratio R is selected by `cfg_ratio`: 0 gives 256, 1 gives 384, 2 gives 512, 3 gives 768, and 4 to 7 give 1024. One bit period lasts D = max(2, floor(R/(32·N))) master clocks. `sck` is low for the first D−D/2 of them (rounded down) and high for the rest.
- R3: A frame spans 32·N bit periods, counted from the first bit after enable. The `cfg_fs_mode` field shapes `fsync` as follows. Value 0 keeps it high for the first 32 bits of the frame. Value 1 keeps it high for the first 16·N bits. Value 2 keeps it high only for bit 0. Value 3 behaves like value 0.
- R4: Slot k carries channel k, most significant bit first. Data changes only at a bit start, which is when `sck` falls or when the block is enabled. When `cfg_i2s` is 1, each slot's data lags the slot boundary by one bit.
- R5: If a slot begins while its channel store is empty and repeat is not permitted, the slot sends all zeros.
- R6: Repeat is permitted only when `cfg_repeat`=1, `cfg_i2s`=1 and N=2. In that case an empty slot resends the last sample that was actually taken from that channel's store.
- R7: `in_ready` is high when the addressed channel's store is empty. It is also high, and the write is discarded, when `in_chan` ≥ N or when mono is on and `in_chan` is odd.
- R8: `urun` becomes 1 in the cycle after a slot begins with an empty store. It stays 1 until `urun_clr` is high at a clock edge with no new underrun at that edge. A new underrun wins over a clear.
- R9: With `cfg_mono`=1, each odd slot resends the word sent in the even slot before it. An odd slot never consumes a store and never raises an underrun.
- R10: `rx_sd` equals `sd_out` when `cfg_loop`=1 and equals `sd_in` otherwise.
- R11: The first bit starts at the first edge that sees `cfg_en` high. The block returns to `BC_OFF` at the first edge that sees it low. Channel stores keep their contents across a disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Run enable |
| cfg_nch_m1 | input | 3 | Channel count minus one |
| cfg_ratio | input | 3 | Master-clock to sample-rate ratio select |
| cfg_fs_mode | input | 2 | Frame-sync pulse shape |
| cfg_i2s | input | 1 | One-bit data delay after the slot boundary |
| cfg_mono | input | 1 | Duplicate even slots into odd slots |
| cfg_repeat | input | 1 | Underrun fill: 0 zero, 1 repeat (when permitted) |
| cfg_loop | input | 1 | Route serial output to receive data |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample taken at this edge if valid |
| in_chan | input | 3 | Target channel of the sample |
| in_data | input | 32 | Sample word |
| urun_clr | input | 1 | Clear pulse for the underrun flag |
| sd_in | input | 1 | External serial receive data |
| sck | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sd_out | output | 1 | Serial data |
| rx_sd | output | 1 | Receive-path data after the loop-back select |
| urun | output | 1 | Sticky underrun flag |

## Verification
The serial output is exercised under several conditions: with stores filled ahead of enable, with steady round-robin feeding, and with feeding stopped. These three cases separate correct slot-to-channel mapping from stale or shifted words, and show the zero fill and the repeat fill on the same stream. Sample writes to channels above the configured count and to odd channels in mono mode show that the discard path leaves the output untouched. Odd divisors (three master clocks per bit) and the reserved frame-sync code test the uneven clock split and the fallback pulse shape. A disable in the middle of a frame followed by re-enable tests the restart point and shows that the stores survive.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        BC_OFF  = 2'd0,
        BC_LOW  = 2'd1,
        BC_HIGH = 2'd2
    } bc_state_e;

    typedef enum logic [1:0] {
        FS_SLOT = 2'd0,
        FS_HALF = 2'd1,
        FS_BIT  = 2'd2,
        FS_RSVD = 2'd3
    } fs_shape_e;

    localparam int RATIO_W = 11;

    function automatic logic [RATIO_W-1:0] ratio_value(input logic [2:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0:    r = RATIO_W'(256);
            3'd1:    r = RATIO_W'(384);
            3'd2:    r = RATIO_W'(512);
            3'd3:    r = RATIO_W'(768);
            default: r = RATIO_W'(1024);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk
    import tdm_tx_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int SLOT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [$clog2(MAX_CH)-1:0]   nch_m1,
    input  logic [2:0]                  ratio,
    input  logic [1:0]                  fs_mode,
    input  logic                        i2s,
    output logic [$clog2(MAX_CH):0]     nch,
    output logic                        sck,
    output logic                        fsync,
    output logic                        run,
    output logic                        start,
    output logic                        bit_start,
    output logic                        load,
    output logic [$clog2(MAX_CH)-1:0]   load_slot
);
    localparam int CH_W  = $clog2(MAX_CH);
    localparam int NCH_W = CH_W + 1;
    localparam int SB    = $clog2(SLOT_W);
    localparam int FB_W  = $clog2(MAX_CH * SLOT_W);

    bc_state_e          state_q, state_d;
    logic [RATIO_W-1:0] cnt_q;
    logic [FB_W-1:0]    fbit_q;
    logic [FB_W:0]      fbits;
    logic [RATIO_W-1:0] div_raw, div, lo;
    logic [FB_W-1:0]    fbit_nxt, dpos;
    logic               bit_end;

    assign nch     = ({1'b0, nch_m1} | NCH_W'(1)) + NCH_W'(1);
    assign fbits   = (FB_W+1)'(nch) << SB;
    assign div_raw = ratio_value(ratio) / RATIO_W'(fbits);
    assign div     = (div_raw < RATIO_W'(2)) ? RATIO_W'(2) : div_raw;
    assign lo      = div - (div >> 1);
    assign bit_end = (cnt_q == div - RATIO_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BC_OFF:  if (en) state_d = BC_LOW;
            BC_LOW:  if (!en) state_d = BC_OFF;
                     else if (cnt_q == lo - RATIO_W'(1)) state_d = BC_HIGH;
            BC_HIGH: if (!en) state_d = BC_OFF;
                     else if (bit_end) state_d = BC_LOW;
            default: state_d = BC_OFF;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BC_OFF;
            cnt_q   <= '0;
            fbit_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == BC_OFF || bit_start) cnt_q <= '0;
            else                                cnt_q <= cnt_q + RATIO_W'(1);
            if (state_d == BC_OFF) fbit_q <= '0;
            else if (bit_start)    fbit_q <= fbit_nxt;
        end
    end

    // bit-start decode
    always_comb begin
        bit_start = en && (state_q == BC_OFF || (state_q == BC_HIGH && bit_end));
        if (state_q == BC_OFF)                       fbit_nxt = '0;
        else if ({1'b0, fbit_q} == fbits - 1'b1)     fbit_nxt = '0;
        else                                         fbit_nxt = fbit_q + FB_W'(1);
        if (!i2s)                dpos = fbit_nxt;
        else if (fbit_nxt == '0) dpos = FB_W'(fbits - 1'b1);
        else                     dpos = fbit_nxt - FB_W'(1);
        load      = bit_start && (dpos[SB-1:0] == '0);
        load_slot = CH_W'(dpos >> SB);
    end

    // outputs
    always_comb begin
        sck   = (state_q == BC_HIGH);
        run   = (state_q != BC_OFF);
        start = en && (state_q == BC_OFF);
        fsync = 1'b0;
        if (run) begin
            unique case (fs_shape_e'(fs_mode))
                FS_HALF: fsync = ({1'b0, fbit_q} < (fbits >> 1));
                FS_BIT:  fsync = (fbit_q == '0);
                default: fsync = ({1'b0, fbit_q} < (FB_W+1)'(SLOT_W));
            endcase
        end
    end

endmodule

// File: rtl/tdm_slot_store.sv
module tdm_slot_store #(
    parameter int MAX_CH = 8,
    parameter int SLOT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mono,
    input  logic                       rep_ok,
    input  logic                       wr_req,
    input  logic [$clog2(MAX_CH)-1:0]  wr_chan,
    input  logic [SLOT_W-1:0]          wr_data,
    input  logic                       load,
    input  logic [$clog2(MAX_CH)-1:0]  load_slot,
    output logic [MAX_CH-1:0]          slot_full,
    output logic [SLOT_W-1:0]          load_word,
    output logic                       urun_evt
);
    localparam int CH_W = $clog2(MAX_CH);

    logic [SLOT_W-1:0] smp_q  [MAX_CH];
    logic [SLOT_W-1:0] prev_q [MAX_CH];
    logic [SLOT_W-1:0] hold_q;
    logic              dup_slot;

    assign dup_slot = mono && load_slot[0];

    for (genvar g = 0; g < MAX_CH; g++) begin : g_chan
        logic take_g, put_g;
        assign take_g = load && !dup_slot && (load_slot == CH_W'(g));
        assign put_g  = wr_req && (wr_chan == CH_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[g]     <= '0;
                prev_q[g]    <= '0;
                slot_full[g] <= 1'b0;
            end else begin
                if (take_g && slot_full[g]) prev_q[g] <= smp_q[g];
                if (put_g) begin
                    smp_q[g]     <= wr_data;
                    slot_full[g] <= 1'b1;
                end else if (take_g) begin
                    slot_full[g] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        urun_evt = 1'b0;
        if (dup_slot)                 load_word = hold_q;
        else if (slot_full[load_slot]) load_word = smp_q[load_slot];
        else begin
            urun_evt  = load;
            load_word = rep_ok ? prev_q[load_slot] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     hold_q <= '0;
        else if (load && !load_slot[0]) hold_q <= load_word;
    end

endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
    parameter int SLOT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_start,
    input  logic              load,
    input  logic [SLOT_W-1:0] word,
    output logic              msb
);
    logic [SLOT_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sr_q <= '0;
        else if (load)      sr_q <= word;
        else if (start)     sr_q <= '0;
        else if (bit_start) sr_q <= sr_q << 1;
    end

    assign msb = sr_q[SLOT_W-1];

endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx #(
    parameter int MAX_CH = 8,
    parameter int SLOT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_en,
    input  logic [$clog2(MAX_CH)-1:0]  cfg_nch_m1,
    input  logic [2:0]                 cfg_ratio,
    input  logic [1:0]                 cfg_fs_mode,
    input  logic                       cfg_i2s,
    input  logic                       cfg_mono,
    input  logic                       cfg_repeat,
    input  logic                       cfg_loop,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [$clog2(MAX_CH)-1:0]  in_chan,
    input  logic [SLOT_W-1:0]          in_data,
    input  logic                       urun_clr,
    input  logic                       sd_in,
    output logic                       sck,
    output logic                       fsync,
    output logic                       sd_out,
    output logic                       rx_sd,
    output logic                       urun
);
    localparam int CH_W = $clog2(MAX_CH);

    logic [CH_W:0]       ch_total;
    logic                run, start, bit_start, load, urun_evt, msb;
    logic [CH_W-1:0]     load_slot;
    logic [MAX_CH-1:0]   slot_full;
    logic [SLOT_W-1:0]   load_word;
    logic                drop, wr_req, rep_ok;

    tdm_bitclk #(.MAX_CH(MAX_CH), .SLOT_W(SLOT_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .nch_m1(cfg_nch_m1),
        .ratio(cfg_ratio), .fs_mode(cfg_fs_mode), .i2s(cfg_i2s),
        .nch(ch_total), .sck(sck), .fsync(fsync), .run(run), .start(start),
        .bit_start(bit_start), .load(load), .load_slot(load_slot)
    );

    assign drop     = ({1'b0, in_chan} >= ch_total) || (cfg_mono && in_chan[0]);
    assign in_ready = drop || !slot_full[in_chan];
    assign wr_req   = in_valid && !drop && !slot_full[in_chan];
    assign rep_ok   = cfg_repeat && cfg_i2s && (ch_total == (CH_W+1)'(2));

    tdm_slot_store #(.MAX_CH(MAX_CH), .SLOT_W(SLOT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .mono(cfg_mono), .rep_ok(rep_ok),
        .wr_req(wr_req), .wr_chan(in_chan), .wr_data(in_data),
        .load(load), .load_slot(load_slot), .slot_full(slot_full),
        .load_word(load_word), .urun_evt(urun_evt)
    );

    tdm_shifter #(.SLOT_W(SLOT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_start(bit_start),
        .load(load), .word(load_word), .msb(msb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) urun <= 1'b0;
        else        urun <= urun_evt || (urun && !urun_clr);
    end

    assign sd_out = run && msb;
    assign rx_sd  = cfg_loop ? sd_out : sd_in;

endmodule

// File: rtl/tdm_audio_tx_sva.sv
module tdm_audio_tx_sva #(
    parameter int MAX_CH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_en,
    input logic                      cfg_mono,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [$clog2(MAX_CH)-1:0] in_chan,
    input logic [$clog2(MAX_CH):0]   ch_total,
    input logic [MAX_CH-1:0]         slot_full,
    input logic                      urun,
    input logic                      urun_clr,
    input logic                      sck,
    input logic                      fsync,
    input logic                      sd_out
);
    // R1: disabled block keeps its serial pins low
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en) |-> (!sck && !fsync && !sd_out));

    // R2: a high bit-clock phase is only reached from an enabled run
    a_r2_sck_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $past(cfg_en));

    // R3: frame sync starts at a falling bit-clock boundary
    a_r3_sync_rises_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> !sck);

    // R4: serial data only moves while the bit clock is low
    a_r4_sd_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && $past(cfg_en) && (sd_out != $past(sd_out))) |-> !sck);

    // R7: an accepted sample fills the addressed store
    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ({1'b0, in_chan} < ch_total) && !(cfg_mono && in_chan[0]))
        |=> slot_full[$past(in_chan)]);

    // R8: the underrun flag holds until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !urun_clr) |=> urun);

endmodule

bind tdm_audio_tx tdm_audio_tx_sva #(.MAX_CH(MAX_CH)) u_sva (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mono(cfg_mono),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .ch_total(ch_total), .slot_full(slot_full), .urun(urun),
    .urun_clr(urun_clr), .sck(sck), .fsync(fsync), .sd_out(sd_out)
);

// File: tb/tdm_audio_tx_test.sv
`timescale 1ns/1ps
module tdm_audio_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_nch_m1 = 3'd1;
    logic [2:0]  cfg_ratio = 3'd0;
    logic [1:0]  cfg_fs_mode = 2'd0;
    logic        cfg_i2s = 1'b0, cfg_mono = 1'b0, cfg_repeat = 1'b0, cfg_loop = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_chan = 3'd0;
    logic [31:0] in_data = 32'd0;
    logic        urun_clr = 1'b0;
    logic        sd_in = 1'b0;
    logic        in_ready, sck, fsync, sd_out, rx_sd, urun;

    tdm_audio_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_nch_m1(cfg_nch_m1),
        .cfg_ratio(cfg_ratio), .cfg_fs_mode(cfg_fs_mode), .cfg_i2s(cfg_i2s),
        .cfg_mono(cfg_mono), .cfg_repeat(cfg_repeat), .cfg_loop(cfg_loop),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
        .in_data(in_data), .urun_clr(urun_clr), .sd_in(sd_in),
        .sck(sck), .fsync(fsync), .sd_out(sd_out), .rx_sd(rx_sd), .urun(urun)
    );

    always #10 clk = ~clk;

    int    checks = 0, failures = 0, cyc = 0;
    bit    comparing = 1'b0, finished = 1'b0;
    string tag = "R4";

    // behavioural reference state
    int          mst = 0, mc = 0, mfb = 0;
    logic [31:0] msr = 0, mhold = 0;
    logic [31:0] mbuf [8];
    logic [31:0] mprev [8];
    bit          mbv [8];
    bit          murun = 0;
    int          m_nch, m_div, m_lo, m_fb, m_nf, m_dpos, m_slot, m_ch;
    bit          m_bs, m_wr, m_evt;

    function automatic int ratio_of(input int c);
        case (c)
            0: return 256; 1: return 384; 2: return 512; 3: return 768;
            default: return 1024;
        endcase
    endfunction

    function automatic int nch_of();
        return (int'(cfg_nch_m1) | 1) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mc = 0; mfb = 0; msr = 0; mhold = 0; murun = 0;
            for (int i = 0; i < 8; i++) begin mbuf[i] = 0; mprev[i] = 0; mbv[i] = 0; end
        end else begin
            m_nch = nch_of();
            m_div = ratio_of(int'(cfg_ratio)) / (32 * m_nch);
            if (m_div < 2) m_div = 2;
            m_lo = m_div - m_div / 2;
            m_fb = 32 * m_nch;
            m_ch = int'(in_chan);
            m_wr = in_valid && !(m_ch >= m_nch || (cfg_mono && m_ch % 2 == 1)) && !mbv[m_ch];
            m_bs = 0; m_evt = 0; m_nf = mfb;
            if (!cfg_en) begin
                mst = 0; mc = 0; mfb = 0;
            end else if (mst == 0) begin
                mst = 1; mc = 0; m_nf = 0; m_bs = 1; msr = 0;
            end else if (mst == 1) begin
                if (mc == m_lo - 1) mst = 2;
                mc++;
            end else begin
                if (mc == m_div - 1) begin
                    mst = 1; mc = 0; m_bs = 1;
                    m_nf = (mfb == m_fb - 1) ? 0 : mfb + 1;
                end else mc++;
            end
            if (m_bs) begin
                mfb = m_nf;
                m_dpos = cfg_i2s ? (m_nf + m_fb - 1) % m_fb : m_nf;
                if (m_dpos % 32 == 0) begin
                    m_slot = m_dpos / 32;
                    if (cfg_mono && m_slot % 2 == 1) msr = mhold;
                    else if (mbv[m_slot]) begin
                        msr = mbuf[m_slot]; mprev[m_slot] = mbuf[m_slot]; mbv[m_slot] = 0;
                    end else begin
                        m_evt = 1;
                        msr = (cfg_repeat && cfg_i2s && m_nch == 2) ? mprev[m_slot] : 32'd0;
                    end
                    if (m_slot % 2 == 0) mhold = msr;
                end else msr = msr << 1;
            end
            if (m_wr) begin mbuf[m_ch] = in_data; mbv[m_ch] = 1; end
            murun = m_evt || (murun && !urun_clr);
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, well away from the active edge
    always @(negedge clk) begin
        #5;
        if (comparing) begin
            logic e_fs, e_sd, e_rdy;
            int n, fb, ch;
            n = nch_of(); fb = 32 * n; ch = int'(in_chan);
            case (cfg_fs_mode)
                2'd1: e_fs = (mst != 0) && (mfb < fb / 2);
                2'd2: e_fs = (mst != 0) && (mfb == 0);
                default: e_fs = (mst != 0) && (mfb < 32);
            endcase
            e_sd  = (mst != 0) && msr[31];
            e_rdy = (ch >= n) || (cfg_mono && ch % 2 == 1) || !mbv[ch];
            chk("R2", "sck", sck, mst == 2);
            chk("R3", "fsync", fsync, e_fs);
            chk(tag, "sd_out", sd_out, e_sd);
            chk("R7", "in_ready", in_ready, e_rdy);
            chk("R8", "urun", urun, murun);
            chk("R10", "rx_sd", rx_sd, cfg_loop ? e_sd : sd_in);
        end
    end

    always @(negedge clk) begin
        cyc++;
        sd_in <= cyc[2] ^ cyc[5];
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic feed(input int n, input int nch, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_chan  = 3'(i % nch);
            in_data  = 32'h9E3779B9 * 32'(i + base + 1);
            #5;
            while (!in_ready) begin @(negedge clk); #5; end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        comparing = 1'b1;
        #5;
        // R1: reset state while disabled
        chk("R1", "sck", sck, 1'b0);
        chk("R1", "fsync", fsync, 1'b0);
        chk("R1", "sd_out", sd_out, 1'b0);
        chk("R1", "urun", urun, 1'b0);
        chk("R1", "in_ready", in_ready, 1'b1);

        // R6: two channels, I2S delay, repeat on underrun
        tag = "R6";
        cfg_nch_m1 = 3'd1; cfg_ratio = 3'd0; cfg_fs_mode = 2'd0;
        cfg_i2s = 1'b1; cfg_repeat = 1'b1;
        feed(2, 2, 0);
        cfg_en = 1'b1;
        feed(6, 2, 10);
        idle(800);
        chk("R8", "urun after starve", urun, 1'b1);
        cfg_en = 1'b0;
        idle(2);
        urun_clr = 1'b1;
        idle(1);
        urun_clr = 1'b0;
        #5;
        chk("R8", "urun after clear", urun, 1'b0);

        // R5: four channels, odd divisor, half-frame sync, zero fill
        tag = "R5";
        cfg_nch_m1 = 3'd3; cfg_ratio = 3'd1; cfg_fs_mode = 2'd1;
        cfg_i2s = 1'b0; cfg_repeat = 1'b1;
        feed(4, 4, 20);
        cfg_en = 1'b1;
        feed(8, 4, 30);
        idle(800);
        cfg_en = 1'b0;
        idle(3);

        // R4: eight channels, single-bit sync, I2S delay
        tag = "R4";
        cfg_nch_m1 = 3'd7; cfg_ratio = 3'd4; cfg_fs_mode = 2'd2;
        cfg_i2s = 1'b1; cfg_repeat = 1'b0;
        feed(8, 8, 40);
        cfg_en = 1'b1;
        feed(16, 8, 50);
        idle(1100);
        cfg_en = 1'b0;
        idle(3);

        // R7: six channels, writes to channels 6 and 7 discarded, reserved sync code
        tag = "R7";
        cfg_nch_m1 = 3'd5; cfg_ratio = 3'd1; cfg_fs_mode = 2'd3;
        cfg_i2s = 1'b0;
        feed(8, 8, 60);
        cfg_en = 1'b1;
        feed(24, 8, 70);
        idle(400);
        cfg_en = 1'b0;
        idle(3);

        // R9: mono, field low bit ignored (0 -> two channels), loop-back switched mid-run
        tag = "R9";
        cfg_nch_m1 = 3'd0; cfg_ratio = 3'd2; cfg_fs_mode = 2'd0;
        cfg_mono = 1'b1;
        feed(2, 2, 80);
        cfg_en = 1'b1;
        feed(4, 2, 90);
        cfg_loop = 1'b1;   // R10
        feed(4, 2, 100);
        idle(1100);
        cfg_en = 1'b0;
        idle(3);
        cfg_mono = 1'b0; cfg_loop = 1'b0;

        // R11: disable mid-frame, stores survive, restart from bit 0
        tag = "R11";
        cfg_nch_m1 = 3'd1; cfg_ratio = 3'd0; cfg_i2s = 1'b0;
        feed(2, 2, 110);
        cfg_en = 1'b1;
        idle(100);
        feed(1, 2, 120);
        cfg_en = 1'b0;
        idle(10);
        cfg_en = 1'b1;
        feed(4, 2, 130);
        idle(300);
        cfg_en = 1'b0;
        idle(4);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule